// File: doc/BRIEF.md
# Training Pattern Insertion Multiplexer

This block sits on the transmit side of a parallel link that carries sixteen data lanes and one data-valid lane. Each lane delivers one 4-bit word per cycle of a half-rate clock to its own 4:1 serializer. The far end asks for link alignment through an init-active signal. While that signal is high, every lane carries a fixed training word instead of user traffic. The receiver shifts its capture point until it sees the word it expects. When init-active falls, the block goes back to passing the parallel data and valid words through.

Init-active comes from the other side of the link and is asynchronous to the transmit clock, so it is first brought through a two-flop synchronizer. A mode register then takes the synchronized value, and mode changes only at half-rate clock edges. Because every edge is also a word boundary, the output register holds either a complete training word or a complete data word on every lane. While the block is in reset it already drives the training word. The pattern is therefore on the lanes before the receiver's own reset is released.

The word is ordered for the serializer. Bit k of a lane word is the (k+1)-th bit sent, so the word written here as 4'b0100 is sent as 0,0,1,0. After the serializer and deserializer reorder it, the receiver sees 0100.

Top module: `tpi_tx_top`

## Requirements
- R1: While rst_ni is low, after every rising edge each of the 17 lane words equals 4'b0100. Bit 0 is the first bit serialized, so the lane bits are sent in the order 0,0,1,0.
- R2: In training mode all 16 data-lane words on lane_data_o equal 4'b0100, whatever is on tx_data_i.
- R3: In training mode lane_valid_o equals 4'b0100, whatever is on tx_valid_i.
- R4: The value of init_active_i sampled at rising edge n decides the mode of the output word registered at edge n+3. The output therefore changes after the fourth rising edge that sees the new level, in both directions.
- R5: In normal mode, data lane i of lane_data_o (bits 4i+3..4i) equals tx_data_i lane i as sampled at the same rising edge. This is a single register of latency.
- R6: In normal mode lane_valid_o equals tx_valid_i as sampled at the same rising edge.
- R7: While training continues, the training word repeats on consecutive cycles with no gap or change.
- R8: All 17 lanes change mode on the same edge. No output cycle mixes training words and data words, and even an init pulse one cycle long yields exactly one full training cycle.
- R9: When rst_ni rises while init_active_i is high, the training word continues without a break across the release of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Half-rate transmit clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| init_active_i | input | 1 | Asynchronous training request from the receiver |
| tx_data_i | input | 64 | Normal data, one 4-bit word per data lane |
| tx_valid_i | input | 4 | Normal data-valid word |
| lane_data_o | output | 64 | Words to the 16 data-lane serializers |
| lane_valid_o | output | 4 | Word to the valid-lane serializer |

## Verification
Data and valid words are due one edge after they are presented. A change of init_active_i shows up on the lanes after the fourth edge, and the reset word appears from the first edge in reset. The bench drives inputs on falling edges. For each edge it pushes the expected 17-lane output into a queue, using a model of the three-edge mode delay. The monitor pops one item a short time after each rising edge, so every comparison lines up with the edge that produced the output. The stimulus covers release of reset with training held, both mode transitions, a one-cycle init pulse, and data words that are all ones, all zeros, incrementing, and equal to the training word.

// File: rtl/tpi_pkg.sv
// Package tpi_pkg
// Shared defaults for the training pattern insertion block.
// Assumes 4-bit lane words, with bit 0 being the first bit serialized.
package tpi_pkg;
    localparam int unsigned DEF_WORD_W   = 4;
    localparam int unsigned DEF_NUM_DATA = 16;
    localparam int unsigned DEF_SYNC_LEN = 2;
    // Serializer order 0,0,1,0 (bit 0 first) gives 0100 at the far end.
    localparam logic [DEF_WORD_W-1:0] DEF_TRAIN_WORD = 4'b0100;

    // Mode of the output register.
    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_TRAIN  = 1'b1
    } tpi_mode_e;
endpackage

// File: rtl/tpi_sync.sv
// Module tpi_sync
// Multi-flop synchronizer for one asynchronous level.
// Assumes the input is a slow level. Reset value is a parameter, so the
// block can come out of reset already asking for training.
module tpi_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/tpi_mode_ctrl.sv
// Module tpi_mode_ctrl
// Keeps the insertion mode, taken once per word period from the
// synchronized init level, so a change always lands on a word boundary.
// Assumes one clock edge per 4-bit word. Reset leaves it in training.
module tpi_mode_ctrl
    import tpi_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      init_sync_i,
    output tpi_mode_e mode_o
);
    tpi_mode_e mode_q;
    tpi_mode_e mode_d;

    // Choose the mode for the next word period.
    always_comb begin
        mode_d = init_sync_i ? MODE_TRAIN : MODE_NORMAL;
    end

    // Hold the mode for one full word period.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            mode_q <= MODE_TRAIN;
        end else begin
            mode_q <= mode_d;
        end
    end

    assign mode_o = mode_q;
endmodule

// File: rtl/tpi_lane_mux.sv
// Module tpi_lane_mux
// Registered two-way select for one lane: the training word or the
// lane's parallel word. Assumes the mode is already in the clock domain.
// Reset loads the training word.
module tpi_lane_mux
    import tpi_pkg::*;
#(
    parameter int unsigned         WORD_W     = DEF_WORD_W,
    parameter logic [WORD_W-1:0]   TRAIN_WORD = DEF_TRAIN_WORD
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  tpi_mode_e         mode_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [WORD_W-1:0] word_o
);
    logic [WORD_W-1:0] sel_d;
    logic [WORD_W-1:0] word_q;

    // Pick the training word or the data word for this lane.
    always_comb begin
        sel_d = (mode_i == MODE_TRAIN) ? TRAIN_WORD : word_i;
    end

    // Register a whole lane word each half-rate cycle.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            word_q <= TRAIN_WORD;
        end else begin
            word_q <= sel_d;
        end
    end

    assign word_o = word_q;
endmodule

// File: rtl/tpi_tx_top.sv
// Module tpi_tx_top
// Training pattern insertion for a 16-data-lane plus valid-lane link.
// Synchronizes init-active, keeps a word-aligned mode, and drives every
// lane's serializer word through a registered select. Assumes one
// 4:1 serializer per lane outside this block on the same clock.
module tpi_tx_top
    import tpi_pkg::*;
#(
    parameter int unsigned       WORD_W     = DEF_WORD_W,
    parameter int unsigned       NUM_DATA   = DEF_NUM_DATA,
    parameter int unsigned       SYNC_LEN   = DEF_SYNC_LEN,
    parameter logic [WORD_W-1:0] TRAIN_WORD = DEF_TRAIN_WORD
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       init_active_i,
    input  logic [NUM_DATA*WORD_W-1:0] tx_data_i,
    input  logic [WORD_W-1:0]          tx_valid_i,
    output logic [NUM_DATA*WORD_W-1:0] lane_data_o,
    output logic [WORD_W-1:0]          lane_valid_o
);
    localparam int unsigned NUM_LANES = NUM_DATA + 1;
    localparam int unsigned BUS_W     = NUM_LANES * WORD_W;

    logic              init_sync;
    tpi_mode_e         mode;
    logic [BUS_W-1:0]  lane_in;
    logic [BUS_W-1:0]  lane_out;

    // Bring the asynchronous request into the clock domain.
    tpi_sync #(
        .STAGES  (SYNC_LEN),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (init_active_i),
        .sync_o  (init_sync)
    );

    // Keep the word-aligned insertion mode.
    tpi_mode_ctrl u_mode (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .init_sync_i (init_sync),
        .mode_o      (mode)
    );

    // The valid lane sits above the data lanes as the last lane.
    assign lane_in = {tx_valid_i, tx_data_i};

    // One registered select per lane, all sharing the mode.
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        tpi_lane_mux #(
            .WORD_W     (WORD_W),
            .TRAIN_WORD (TRAIN_WORD)
        ) u_mux (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .mode_i (mode),
            .word_i (lane_in[g*WORD_W +: WORD_W]),
            .word_o (lane_out[g*WORD_W +: WORD_W])
        );
    end

    assign lane_data_o  = lane_out[NUM_DATA*WORD_W-1:0];
    assign lane_valid_o = lane_out[BUS_W-1 -: WORD_W];
endmodule

// File: rtl/tpi_tx_checker.sv
// Module tpi_tx_checker
// Properties of the insertion block, bound to tpi_tx_top.
// Assumes that the inputs are driven from time zero.
module tpi_tx_checker
    import tpi_pkg::*;
#(
    parameter int unsigned       WORD_W     = DEF_WORD_W,
    parameter int unsigned       NUM_DATA   = DEF_NUM_DATA,
    parameter logic [WORD_W-1:0] TRAIN_WORD = DEF_TRAIN_WORD
) (
    input logic                       clk_i,
    input logic                       rst_ni,
    input tpi_mode_e                  mode,
    input logic [NUM_DATA*WORD_W-1:0] tx_data_i,
    input logic [WORD_W-1:0]          tx_valid_i,
    input logic [NUM_DATA*WORD_W-1:0] lane_data_o,
    input logic [WORD_W-1:0]          lane_valid_o
);
    localparam logic [NUM_DATA*WORD_W-1:0] ALL_TRAIN = {NUM_DATA{TRAIN_WORD}};

    // R1: a reset edge leaves the training word on every lane.
    p_reset_word_r1: assert property (@(posedge clk_i)
        !rst_ni |=> (lane_data_o == ALL_TRAIN && lane_valid_o == TRAIN_WORD));

    // R2: training mode puts the word on all data lanes.
    p_train_data_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode == MODE_TRAIN) |=> (lane_data_o == ALL_TRAIN));

    // R3: training mode puts the word on the valid lane.
    p_train_valid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode == MODE_TRAIN) |=> (lane_valid_o == TRAIN_WORD));

    // R5: normal mode passes data with one register of delay.
    p_pass_data_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode == MODE_NORMAL) |=> (lane_data_o == $past(tx_data_i)));

    // R6: normal mode passes the valid word.
    p_pass_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode == MODE_NORMAL) |=> (lane_valid_o == $past(tx_valid_i)));

    // R7: back-to-back training words do not change.
    p_repeat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode == MODE_TRAIN && $past(mode) == MODE_TRAIN && $past(rst_ni))
        |=> ($stable(lane_data_o) && $stable(lane_valid_o)));
endmodule

bind tpi_tx_top tpi_tx_checker #(
    .WORD_W     (WORD_W),
    .NUM_DATA   (NUM_DATA),
    .TRAIN_WORD (TRAIN_WORD)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mode         (mode),
    .tx_data_i    (tx_data_i),
    .tx_valid_i   (tx_valid_i),
    .lane_data_o  (lane_data_o),
    .lane_valid_o (lane_valid_o)
);

// File: tb/sim_tpi_tx_top.sv
// Scoreboard bench for tpi_tx_top.
module sim_tpi_tx_top;
    localparam int DW = 64;
    localparam logic [3:0] TW = 4'b0100;

    typedef struct {
        logic [DW-1:0] exp_d;
        logic [3:0]    exp_v;
        string         tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          init_a = 1'b1;
    logic [DW-1:0] din = '0;
    logic [3:0]    vin = '0;
    logic [DW-1:0] dout;
    logic [3:0]    vout;

    item_t q[$];
    int checks = 0;
    int fails = 0;
    bit done = 0;
    // Model of the three-edge mode delay (R4), all high after reset.
    logic h1 = 1'b1, h2 = 1'b1, h3 = 1'b1;

    tpi_tx_top u0 (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .init_active_i (init_a),
        .tx_data_i     (din),
        .tx_valid_i    (vin),
        .lane_data_o   (dout),
        .lane_valid_o  (vout)
    );

    always #4 clk = ~clk;

    // Drive one cycle and push the output expected after the next edge.
    task automatic drive(input logic r, input logic ini, input logic [DW-1:0] d,
                         input logic [3:0] v, input string tag);
        item_t it;
        @(negedge clk);
        rst_n = r; init_a = ini; din = d; vin = v;
        it.tag = tag;
        if (!r || h3) begin
            it.exp_d = {16{TW}};
            it.exp_v = TW;
        end else begin
            it.exp_d = d;
            it.exp_v = v;
        end
        q.push_back(it);
        if (!r) begin
            h1 = 1'b1; h2 = 1'b1; h3 = 1'b1;
        end else begin
            h3 = h2; h2 = h1; h1 = ini;
        end
    endtask

    // Monitor: compare each output shortly after the edge that made it.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                checks++;
                if (dout !== it.exp_d) begin
                    fails++;
                    $display("FAIL %s data lanes: actual=%h expected=%h", it.tag, dout, it.exp_d);
                end
                checks++;
                if (vout !== it.exp_v) begin
                    fails++;
                    $display("FAIL %s valid lane: actual=%h expected=%h", it.tag, vout, it.exp_v);
                end
            end
        end
    end

    initial begin
        // R1: reset drives the training word regardless of inputs.
        for (int i = 0; i < 4; i++) drive(1'b0, 1'b1, {16{4'hF}}, 4'hF, "R1");
        drive(1'b0, 1'b0, {16{4'h9}}, 4'h9, "R1");
        // R9: release with init held high keeps training unbroken.
        for (int i = 0; i < 3; i++) drive(1'b1, 1'b1, {16{4'hA}}, 4'hF, "R9");
        // R2, R3, R7: training ignores data and repeats.
        for (int i = 0; i < 4; i++)
            drive(1'b1, 1'b1, {4{16'h1234 + 16'(i)}}, 4'(i + 1), "R2/R3/R7");
        // R4: fall of init reaches the lanes on the fourth edge.
        for (int i = 0; i < 4; i++)
            drive(1'b1, 1'b0, {16{4'(i + 5)}}, 4'(i + 9), "R4");
        // R5, R6: several data patterns pass through.
        drive(1'b1, 1'b0, {DW{1'b1}}, 4'hF, "R5/R6");
        drive(1'b1, 1'b0, '0, 4'h0, "R5/R6");
        drive(1'b1, 1'b0, {16{TW}}, TW, "R5/R6");
        for (int i = 0; i < 5; i++)
            drive(1'b1, 1'b0, {4{16'h0F1E + 16'(i * 4369)}}, 4'(3 * i), "R5/R6");
        drive(1'b1, 1'b0, {32{2'b10}}, 4'hA, "R5/R6");
        // R8: one-cycle init pulse gives one full training cycle.
        drive(1'b1, 1'b1, {16{4'h3}}, 4'h3, "R8");
        for (int i = 0; i < 6; i++)
            drive(1'b1, 1'b0, {16{4'(i + 1)}}, 4'(15 - i), "R8");
        // R4: rise of init reaches the lanes on the fourth edge.
        for (int i = 0; i < 6; i++)
            drive(1'b1, 1'b1, {16{4'hC}}, 4'h5, "R4/R2/R3");
        // Reset again mid-traffic returns to training at once (R1).
        drive(1'b1, 1'b0, {16{4'h7}}, 4'h7, "R1");
        drive(1'b0, 1'b0, {16{4'h7}}, 4'h7, "R1");
        drive(1'b0, 1'b0, {16{4'h7}}, 4'h7, "R1");
        repeat (3) @(posedge clk);
        #3;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #800000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule